// File: doc/BRIEF.md
# Staged Regulator Power-Up Sequencer

This block decides when each of a group of voltage regulators is switched on after a start-up event. The default is six regulators. Each regulator has three configuration fields: a two-bit stage selector, an enable bit that admits it to the sequence, and a three-bit delay code. When the start input rises, the block waits a fixed wake-up time. It then works through three stages in order. In each stage, every admitted regulator waits for its own delay and then gets a one-cycle start pulse, and its enable output goes high. The stage ends once every admitted regulator in it has reported that its soft-start is done. The next stage's delays are timed from that point.

Regulators that were already powered in the low-power retention state are named by `hib_keep`. If such a regulator is also admitted, its enable is held high from the start of the sequence and it gets no start pulse. After the third stage completes, a completion flag goes high and can be used to release a system reset. The start input must stay high for the whole sequence. Dropping it at any point cancels the sequence and clears every output, so a non-zero delay in the first stage acts as a debounce window.

Delays are timed in ticks of `TICK_CLKS` clocks. The default is 1000 clocks, which is 0.5 ms at 2 MHz.

Top module: `psq_top`

## Requirements
- R1: The stage selector of regulator i is `cfg_step[2i+1:2i]`. Code 00 selects stage 1 and code 01 selects stage 2. Codes 10 and 11 both select stage 3 and behave identically.
- R2: A regulator whose `cfg_en` bit is 0 never has `reg_en` or `ss_start` high. It does not hold back the completion of its stage or of the sequence.
- R3: The delay code of regulator i is `cfg_dly[3i+2:3i]`. Codes 0 to 7 mean 0, 1, 2, 4, 8, 16, 24 and 32 ticks. One tick is `TICK_CLKS` clocks.
- R4: Each stage is entered one clock after the previous stage completes. Stage 1 is entered after the wake-up time. A regulator with delay d ticks fires at clock d*`TICK_CLKS` after its stage is entered, independently of other regulators in the same stage.
- R5: Stage 1 is entered after `WAKE_CLKS` clocks, counted from the clock edge that samples the rising edge of `start_evt`.
- R6: When `start_evt` is sampled low, the next cycle has `reg_en`, `ss_start` and `seq_done` all at 0 and the sequence is abandoned. Only a new rising edge starts a fresh sequence.
- R7: A regulator with both `hib_keep` and `cfg_en` set at the rising edge has `reg_en` high from the following cycle onward. It receives no start pulse and counts as complete in its stage.
- R8: A stage completes when every admitted, non-retained regulator in it has had `ss_done` high after its start pulse. A stage with no such regulator completes in its first cycle.
- R9: `seq_done` rises in the cycle after stage 3 completes. While it is high, every admitted regulator has `reg_en` high. It falls when `start_evt` is removed.
- R10: A start pulse lasts one cycle and coincides with the rising edge of that regulator's `reg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | Start request; the rising edge begins the sequence, and a low level cancels it |
| hib_keep | input | N_REG | Regulators already powered in the retention state |
| cfg_en | input | N_REG | Per-regulator admission to the sequence |
| cfg_step | input | 2*N_REG | Per-regulator stage selector, two bits each |
| cfg_dly | input | 3*N_REG | Per-regulator delay code, three bits each |
| ss_done | input | N_REG | Soft-start finished report from each regulator |
| reg_en | output | N_REG | Regulator enable |
| ss_start | output | N_REG | One-cycle soft-start trigger |
| seq_done | output | 1 | Whole sequence complete |

## Verification
The assertions assume that `cfg_en`, `cfg_step`, `cfg_dly` and `hib_keep` are only changed while `start_evt` is low, so the configuration is fixed for a whole sequence. The stimulus respects this by loading each configuration vector only while the start input is held low for several cycles. The bench's regulator model raises `ss_done` for a single cycle a fixed latency after each observed start pulse, and never for a regulator that has not been started. Retained-regulator cases hold `hib_keep` steady from before the rising edge until the start input is dropped.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int EL_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAKE = 2'd1,
        ST_STEP = 2'd2,
        ST_DONE = 2'd3
    } psq_state_t;

    // stage selector: both upper codes land on the last stage
    function automatic logic [1:0] stage_of(input logic [1:0] code);
        return (code == 2'b11) ? 2'd2 : code;
    endfunction

    // delay code to tick count
    function automatic logic [EL_W-1:0] ticks_of(input logic [2:0] code);
        logic [EL_W-1:0] t;
        case (code)
            3'd0:    t = 6'd0;
            3'd1:    t = 6'd1;
            3'd2:    t = 6'd2;
            3'd3:    t = 6'd4;
            3'd4:    t = 6'd8;
            3'd5:    t = 6'd16;
            3'd6:    t = 6'd24;
            default: t = 6'd32;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/psq_tick.sv
module psq_tick
    import psq_pkg::*;
#(
    parameter int TICK_CLKS = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [EL_W-1:0] elapsed
);
    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [EL_W-1:0] EL_MAX = '1;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [EL_W-1:0] el;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
            d.el  = '0;
        end else if (q.cnt == CW'(TICK_CLKS - 1)) begin
            d.cnt = '0;
            if (q.el != EL_MAX) begin
                d.el = q.el + 1'b1;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign elapsed = q.el;
endmodule

// File: rtl/psq_slot.sv
module psq_slot
    import psq_pkg::*;
(
    input  logic [1:0]      step_code,
    input  logic            en,
    input  logic [2:0]      dly_code,
    input  logic [1:0]      cur_step,
    input  logic            active,
    input  logic [EL_W-1:0] elapsed,
    input  logic            kept,
    input  logic            started,
    input  logic            done,
    output logic            fire,
    output logic            satisfied
);
    logic member;

    always_comb begin
        member    = en && (stage_of(step_code) == cur_step);
        fire      = active && member && !kept && !started
                    && (elapsed >= ticks_of(dly_code));
        satisfied = !member || kept || done;
    end
endmodule

// File: rtl/psq_top.sv
module psq_top
    import psq_pkg::*;
#(
    parameter int N_REG     = 6,
    parameter int TICK_CLKS = 1000,
    parameter int WAKE_CLKS = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_evt,
    input  logic [N_REG-1:0]   hib_keep,
    input  logic [N_REG-1:0]   cfg_en,
    input  logic [2*N_REG-1:0] cfg_step,
    input  logic [3*N_REG-1:0] cfg_dly,
    input  logic [N_REG-1:0]   ss_done,
    output logic [N_REG-1:0]   reg_en,
    output logic [N_REG-1:0]   ss_start,
    output logic               seq_done
);
    localparam int WK_W = (WAKE_CLKS > 1) ? $clog2(WAKE_CLKS) : 1;
    localparam logic [1:0] LAST_STEP = 2'd2;

    typedef struct packed {
        psq_state_t      st;
        logic [1:0]      step;
        logic [WK_W-1:0] wake;
        logic            evt;
        logic [N_REG-1:0] kept;
        logic [N_REG-1:0] started;
        logic [N_REG-1:0] done;
        logic [N_REG-1:0] en;
        logic [N_REG-1:0] pulse;
        logic            fin;
    } seq_t;

    seq_t q, d;

    logic            tick_clr;
    logic [EL_W-1:0] elapsed;
    logic [N_REG-1:0] fire;
    logic [N_REG-1:0] satisfied;

    psq_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tick_clr),
        .elapsed (elapsed)
    );

    for (genvar g = 0; g < N_REG; g++) begin : g_slot
        psq_slot u_slot (
            .step_code (cfg_step[2*g +: 2]),
            .en        (cfg_en[g]),
            .dly_code  (cfg_dly[3*g +: 3]),
            .cur_step  (q.step),
            .active    (q.st == ST_STEP),
            .elapsed   (elapsed),
            .kept      (q.kept[g]),
            .started   (q.started[g]),
            .done      (q.done[g]),
            .fire      (fire[g]),
            .satisfied (satisfied[g])
        );
    end

    always_comb begin
        d        = q;
        d.evt    = start_evt;
        d.pulse  = '0;
        tick_clr = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start_evt && !q.evt) begin
                    d.st      = ST_WAKE;
                    d.wake    = '0;
                    d.step    = '0;
                    d.kept    = hib_keep & cfg_en;
                    d.en      = hib_keep & cfg_en;
                    d.started = '0;
                    d.done    = '0;
                    d.fin     = 1'b0;
                end
            end
            ST_WAKE: begin
                if (q.wake == WK_W'(WAKE_CLKS - 1)) begin
                    d.st     = ST_STEP;
                    d.step   = '0;
                    tick_clr = 1'b1;
                end else begin
                    d.wake = q.wake + 1'b1;
                end
            end
            ST_STEP: begin
                d.pulse   = fire;
                d.en      = q.en | fire;
                d.started = q.started | fire;
                d.done    = q.done | (ss_done & q.started);
                if (&satisfied) begin
                    if (q.step == LAST_STEP) begin
                        d.st  = ST_DONE;
                        d.fin = 1'b1;
                    end else begin
                        d.step   = q.step + 1'b1;
                        tick_clr = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                d.fin = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        // removal of the start request cancels everything
        if (!start_evt) begin
            d.st    = ST_IDLE;
            d.en    = '0;
            d.pulse = '0;
            d.kept  = '0;
            d.fin   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_en   = q.en;
    assign ss_start = q.pulse;
    assign seq_done = q.fin;
endmodule

// File: rtl/psq_top_chk.sv
module psq_top_chk #(
    parameter int N_REG = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_evt,
    input logic [N_REG-1:0] hib_keep,
    input logic [N_REG-1:0] cfg_en,
    input logic [N_REG-1:0] reg_en,
    input logic [N_REG-1:0] ss_start,
    input logic             seq_done
);
    assert_cancel_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_evt |=> (reg_en == '0 && ss_start == '0 && !seq_done));

    assert_done_all_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> ((reg_en & cfg_en) == cfg_en));

    assert_kept_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_evt) |=> ((reg_en & $past(hib_keep & cfg_en)) == $past(hib_keep & cfg_en)));

    for (genvar g = 0; g < N_REG; g++) begin : g_bit
        assert_pulse_with_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ss_start[g] |-> $rose(reg_en[g]));

        assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ss_start[g] |=> !ss_start[g]);

        assert_disabled_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[g] |-> (!reg_en[g] && !ss_start[g]));
    end
endmodule

bind psq_top psq_top_chk #(.N_REG(N_REG)) u_psq_top_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .hib_keep  (hib_keep),
    .cfg_en    (cfg_en),
    .reg_en    (reg_en),
    .ss_start  (ss_start),
    .seq_done  (seq_done)
);

// File: tb/psq_top_bench.sv
module psq_top_bench;
    localparam int N = 6;
    localparam int T = 4;      // tick length in clocks
    localparam int W = 5;      // wake-up clocks
    localparam int L = 3;      // regulator soft-start latency
    localparam int NV = 5;

    // {hib[5:0], en[5:0], step[11:0] (reg5..reg0), dly[17:0] (reg5..reg0)}
    localparam logic [41:0] VEC [NV] = '{
        {6'b000000, 6'b111111, 12'b01_00_11_10_01_00, 18'b011_000_010_011_000_001},
        {6'b100100, 6'b111011, 12'b01_00_11_10_01_00, 18'b111_001_000_100_010_000},
        {6'b111111, 6'b000000, 12'b00_01_10_11_00_01, 18'b101_010_011_100_001_000},
        {6'b000001, 6'b111111, 12'b11_10_11_10_11_10, 18'b000_001_010_011_100_101},
        {6'b000000, 6'b110111, 12'b00_00_10_11_00_10, 18'b110_000_111_001_000_010}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 1'b0;
    logic [N-1:0]   hib_keep = '0;
    logic [N-1:0]   cfg_en = '0;
    logic [2*N-1:0] cfg_step = '0;
    logic [3*N-1:0] cfg_dly = '0;
    logic [N-1:0]   ss_done = '0;
    logic [N-1:0]   reg_en;
    logic [N-1:0]   ss_start;
    logic           seq_done;

    always #4 clk = ~clk;

    psq_top #(.N_REG(N), .TICK_CLKS(T), .WAKE_CLKS(W)) u_psq_top (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .hib_keep(hib_keep),
        .cfg_en(cfg_en), .cfg_step(cfg_step), .cfg_dly(cfg_dly), .ss_done(ss_done),
        .reg_en(reg_en), .ss_start(ss_start), .seq_done(seq_done)
    );

    int edgecnt = 0;
    int total = 0;
    int bad = 0;
    int det_edge = 0;
    bit armed = 1'b0;
    int st_n [N];
    bit st_seen [N];
    bit twice [N];
    bit en_viol [N];
    bit kept_viol [N];
    int sd_n = 0;
    bit sd_seen = 1'b0;
    logic [N-1:0] kept_m = '0;
    int exp_start [N];
    int exp_done = 0;

    always @(posedge clk) begin
        edgecnt++;
        if (edgecnt > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R8: actual=%0d expected<=%0d", edgecnt, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor and regulator model
    always @(negedge clk) begin
        if (armed) begin
            for (int i = 0; i < N; i++) begin
                if (ss_start[i]) begin
                    if (!st_seen[i]) begin
                        st_seen[i] = 1'b1;
                        st_n[i] = edgecnt - det_edge;
                    end else begin
                        twice[i] = 1'b1;
                    end
                end
                if (reg_en[i] && !cfg_en[i]) en_viol[i] = 1'b1;
                if (kept_m[i] && !reg_en[i]) kept_viol[i] = 1'b1;
            end
            if (seq_done && !sd_seen) begin
                sd_seen = 1'b1;
                sd_n = edgecnt - det_edge;
            end
            for (int i = 0; i < N; i++) begin
                ss_done[i] = st_seen[i] && (edgecnt + 1 == det_edge + st_n[i] + L);
            end
        end else begin
            ss_done = '0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick_wait();
        @(negedge clk);
        #1;
    endtask

    function automatic int dticks(input int c);
        case (c)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            5: return 16;
            6: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic int stage_idx(input int c);
        return (c == 3) ? 2 : c;
    endfunction

    // independent timing model: edge numbers relative to the detecting edge
    task automatic model();
        int base;
        base = W + 1;
        for (int i = 0; i < N; i++) exp_start[i] = -1;
        for (int s = 0; s < 3; s++) begin
            int comp;
            bit any;
            comp = base;
            any = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (cfg_en[i] && !kept_m[i] && stage_idx(int'(cfg_step[2*i +: 2])) == s) begin
                    int f;
                    f = base + dticks(int'(cfg_dly[3*i +: 3])) * T;
                    exp_start[i] = f;
                    if (!any || f + L + 1 > comp) comp = f + L + 1;
                    any = 1'b1;
                end
            end
            if (s == 2) exp_done = comp;
            base = comp + 1;
        end
    endtask

    task automatic arm(input logic [41:0] v);
        start_evt = 1'b0;
        armed = 1'b0;
        hib_keep = v[41:36];
        cfg_en   = v[35:30];
        cfg_step = v[29:18];
        cfg_dly  = v[17:0];
        kept_m   = v[41:36] & v[35:30];
        for (int i = 0; i < N; i++) begin
            st_seen[i] = 1'b0; twice[i] = 1'b0; en_viol[i] = 1'b0;
            kept_viol[i] = 1'b0; st_n[i] = 0;
        end
        sd_seen = 1'b0;
        repeat (3) tick_wait();
        start_evt = 1'b1;
        det_edge = edgecnt + 1;
        armed = 1'b1;
    endtask

    task automatic drop_and_check();
        start_evt = 1'b0;
        tick_wait();
        chk(seq_done == 1'b0, "R9", "seq_done after removal", int'(seq_done), 0);
        chk(reg_en == '0, "R6", "enables after removal", int'(reg_en), 0);
        armed = 1'b0;
        tick_wait();
    endtask

    task automatic run_vec(input int k);
        arm(VEC[k]);
        model();
        while (!sd_seen && (edgecnt - det_edge) < 3000) tick_wait();
        for (int i = 0; i < N; i++) begin
            if (exp_start[i] >= 0) begin
                chk(st_seen[i] && st_n[i] == exp_start[i], "R4",
                    $sformatf("vec%0d reg%0d start edge (R1 R3 R5)", k, i), st_n[i], exp_start[i]);
            end else begin
                chk(!st_seen[i], kept_m[i] ? "R7" : "R2",
                    $sformatf("vec%0d reg%0d no pulse", k, i), int'(st_seen[i]), 0);
            end
            chk(!twice[i], "R10", $sformatf("vec%0d reg%0d single pulse", k, i), int'(twice[i]), 0);
            chk(!en_viol[i], "R2", $sformatf("vec%0d reg%0d disabled stays off", k, i), int'(en_viol[i]), 0);
            chk(!kept_viol[i], "R7", $sformatf("vec%0d reg%0d retained stays on", k, i), int'(kept_viol[i]), 0);
        end
        chk(sd_seen && sd_n == exp_done, "R9", $sformatf("vec%0d seq_done edge (R8)", k), sd_n, exp_done);
        chk(reg_en == cfg_en, "R2", $sformatf("vec%0d final enables", k), int'(reg_en), int'(cfg_en));
        drop_and_check();
    endtask

    initial begin
        repeat (3) tick_wait();
        chk(reg_en == '0 && ss_start == '0 && seq_done == 1'b0, "R6", "outputs in reset",
            int'({reg_en, ss_start, seq_done}), 0);
        rst_n = 1'b1;
        repeat (2) tick_wait();
        chk(reg_en == '0 && seq_done == 1'b0, "R9", "idle after reset",
            int'({reg_en, seq_done}), 0);

        // table walk
        for (int k = 0; k < NV; k++) run_vec(k);

        // debounce: cancel during stage 1 delay, nothing may start
        arm({6'b000000, 6'b000001, 12'b0, 18'b000_000_000_000_000_111});
        repeat (40) tick_wait();
        start_evt = 1'b0;
        repeat (200) tick_wait();
        chk(!st_seen[0], "R6", "debounce cancel no pulse", int'(st_seen[0]), 0);
        chk(reg_en == '0 && !sd_seen, "R6", "debounce cancel outputs idle",
            int'({reg_en, sd_seen}), 0);
        armed = 1'b0;

        // a fresh rising edge restarts cleanly after the cancel
        run_vec(0);

        // empty stage 2 with zero delays: edges of the model still hold
        arm({6'b000000, 6'b000011, 12'b00_00_00_00_10_00, 18'b0});
        model();
        while (!sd_seen && (edgecnt - det_edge) < 3000) tick_wait();
        chk(sd_seen && sd_n == exp_done, "R8", "empty middle stage timing", sd_n, exp_done);
        chk(st_seen[1] && st_n[1] == exp_start[1], "R1", "code 10 runs in stage 3",
            st_n[1], exp_start[1]);
        drop_and_check();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule